// File: doc/BRIEF.md
# Pipeline Stage Gap-Estimating Calibrator

This block corrects the digital word of a 1.5-bit front pipeline stage while the converter keeps running. For every accepted sample it receives the two stage decisions, two near-threshold markers, a random select bit and the raw combined word from the stage and its backend. It forms the stage reference code from those bits, subtracts that code times a learned gap coefficient, and emits the corrected word cut down to the output width.

The gap coefficient is learned in the background. It is learned only from samples marked as lying close to one of the two comparator thresholds. A separate estimator channel serves each threshold. Inside a channel, the select bit sorts corrected samples into a select-high slot and a select-low slot. When a sample completes a high/low pair, the difference (high minus low) is scaled by a power-of-two step and added to the coefficient. This happens in the same clock as that sample's own correction.

The step starts coarse and becomes finer once a sample counter reaches a programmable limit. This lowers the steady-state ripple after the loop has settled.

Top module: `pstage_gap_cal`

## Requirements
- R1: While reset is high, and on the first sample after it, out_valid is 0, corr_word is 0, gap_coef is 0 and fine_step is 0. The sample counter restarts at 0.
- R2: With neither near marker set, the reference code S is chosen from the count of set decision bits: 0 set gives S=-1, 1 set gives S=0, 2 set gives S=+1.
- R3: With near_lo alone set, S=0 when rsel=1 and S=-1 when rsel=0. With near_hi alone set, S=+1 when rsel=1 and S=0 when rsel=0. In both cases the decision bits are ignored.
- R4: A sample with both markers set is treated as unmarked. S follows R2, and the sample neither fills a slot nor changes gap_coef.
- R5: One clock after an accepted sample, out_valid is 1 and corr_word = clamp(floor((raw - floor((S*gap + 2^(FRAC-1)) / 2^FRAC)) / 2^(RAW_W-OUT_W))). Here gap is the coefficient value before that clock's update, and FRAC=10 fractional bits by default. With in_valid low, out_valid is 0 in the next clock.
- R6: Samples with no marker set, and clocks with in_valid low, leave gap_coef unchanged.
- R7: Each channel has a select-high slot and a select-low slot, each with a filled bit. A marked sample whose opposite slot is filled produces an estimate and clears both filled bits. Otherwise the sample overwrites its own slot and sets that slot's filled bit. The estimate is the corrected value (before shift and clamp) of the select-high sample minus that of the select-low sample.
- R8: On an estimate, gap_coef gains floor(est * 2^FRAC / 2^MU). MU is 10 while the count of samples accepted before this one is below phase_limit, and 12 from then on.
- R9: fine_step is 1 exactly when the count of accepted samples is at least phase_limit. The count saturates at its maximum.
- R10: The two channels never pair with each other. A near_hi slot and a near_lo slot together produce no estimate.
- R11: corr_word saturates at +2047 and -2048 (OUT_W=12) when the shifted corrected value lies outside that range.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A sample is present this clock |
| dec_lo | input | 1 | Decision bit of the lower comparator |
| dec_hi | input | 1 | Decision bit of the upper comparator |
| near_lo | input | 1 | Input lies near the lower threshold |
| near_hi | input | 1 | Input lies near the upper threshold |
| rsel | input | 1 | Random select bit used by the stage |
| raw_word | input | RAW_W | Raw combined signed word, in output LSB/4 units |
| phase_limit | input | CNT_W | Sample count at which the step turns fine |
| out_valid | output | 1 | corr_word carries a new result |
| corr_word | output | OUT_W | Corrected, shifted and clamped word |
| gap_coef | output | RAW_W+FRAC+2 | Learned gap coefficient, FRAC fractional bits |
| fine_step | output | 1 | The fine step is in force |

## Verification
A single sample can carry both the correction and the coefficient update: a marked sample that completes a pair is corrected with the old coefficient, and its own corrected value feeds the update. The bench provokes this with pair-completing samples whose code is nonzero, such as near_hi with rsel=1. It judges them by comparing corr_word against the pre-update model coefficient and gap_coef against the post-update one. The step switch can also coincide with an update. The sweep runs across phase_limit, so pairs complete on both sides of the switch, and each is judged against the shift chosen by the count before that sample.

// File: rtl/pgc_pkg.sv
package pgc_pkg;

    // reference code chosen for the stage, signed two-bit encoding
    typedef enum logic [1:0] {
        REF_ZERO = 2'b00,
        REF_POS  = 2'b01,
        REF_NEG  = 2'b11
    } ref_e;

    // per-sample control bits from the stage
    typedef struct packed {
        logic dec_lo;
        logic dec_hi;
        logic near_lo;
        logic near_hi;
        logic rsel;
    } stage_bits_t;

    // a marker counts only when it is the single marker of the sample
    function automatic logic only_lo(stage_bits_t b);
        return b.near_lo & ~b.near_hi;
    endfunction

    function automatic logic only_hi(stage_bits_t b);
        return b.near_hi & ~b.near_lo;
    endfunction

    function automatic ref_e pick_ref(stage_bits_t b);
        ref_e r;
        if (only_lo(b)) begin
            r = b.rsel ? REF_ZERO : REF_NEG;
        end else if (only_hi(b)) begin
            r = b.rsel ? REF_POS : REF_ZERO;
        end else begin
            case ({b.dec_lo, b.dec_hi})
                2'b00:   r = REF_NEG;
                2'b11:   r = REF_POS;
                default: r = REF_ZERO;
            endcase
        end
        return r;
    endfunction

endpackage

// File: rtl/pgc_ref_sel.sv
module pgc_ref_sel
    import pgc_pkg::*;
(
    input  logic        in_valid,
    input  stage_bits_t bits,
    output ref_e        ref_code,
    output logic [1:0]  ch_en
);
    // R2 R3 R4: reference code and channel enables
    always_comb begin
        ref_code = pick_ref(bits);
        ch_en[0] = in_valid & only_lo(bits);
        ch_en[1] = in_valid & only_hi(bits);
    end
endmodule

// File: rtl/pgc_corrector.sv
module pgc_corrector
    import pgc_pkg::*;
#(
    parameter int RAW_W  = 14,
    parameter int OUT_W  = 12,
    parameter int FRAC   = 10,
    parameter int BETA_W = RAW_W + FRAC + 2,
    parameter int CORR_W = BETA_W + 1 - FRAC
) (
    input  logic signed [RAW_W-1:0]  raw,
    input  logic signed [BETA_W-1:0] beta,
    input  ref_e                     ref_code,
    output logic signed [CORR_W-1:0] corr_full,
    output logic signed [OUT_W-1:0]  corr_out
);
    localparam int PW   = BETA_W + 1;
    localparam int DROP = RAW_W - OUT_W;
    localparam logic signed [PW-1:0]     HALF   = PW'(2 ** (FRAC - 1));
    localparam logic signed [CORR_W-1:0] HI_LIM = CORR_W'((2 ** (OUT_W - 1)) - 1);
    localparam logic signed [CORR_W-1:0] LO_LIM = -HI_LIM - CORR_W'(1);

    logic signed [PW-1:0]     scaled;
    logic signed [PW-1:0]     biased;
    logic signed [CORR_W-1:0] rounded;
    logic signed [CORR_W-1:0] shifted;

    always_comb begin
        case (ref_code)
            REF_POS: scaled = PW'(beta);
            REF_NEG: scaled = -PW'(beta);
            default: scaled = '0;
        endcase
        // R5: round to nearest, ties upward
        biased    = scaled + HALF;
        rounded   = CORR_W'(biased >>> FRAC);
        corr_full = CORR_W'(raw) - rounded;
        shifted   = corr_full >>> DROP;
        // R11: saturate to the output range
        if (shifted > HI_LIM) begin
            corr_out = HI_LIM[OUT_W-1:0];
        end else if (shifted < LO_LIM) begin
            corr_out = LO_LIM[OUT_W-1:0];
        end else begin
            corr_out = shifted[OUT_W-1:0];
        end
    end
endmodule

// File: rtl/pgc_est_chan.sv
module pgc_est_chan #(
    parameter int CORR_W = 17,
    parameter int EST_W  = CORR_W + 1
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     en,
    input  logic                     rsel,
    input  logic signed [CORR_W-1:0] corr,
    output logic                     fire,
    output logic signed [EST_W-1:0]  est
);
    logic signed [CORR_W-1:0] hold_hi;
    logic signed [CORR_W-1:0] hold_lo;
    logic                     full_hi;
    logic                     full_lo;

    // R7: a pair completes when the opposite slot is filled
    always_comb begin
        fire = en & (rsel ? full_lo : full_hi);
        if (rsel) begin
            est = EST_W'(corr) - EST_W'(hold_lo);
        end else begin
            est = EST_W'(hold_hi) - EST_W'(corr);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_hi <= '0;
            hold_lo <= '0;
            full_hi <= 1'b0;
            full_lo <= 1'b0;
        end else if (en) begin
            if (fire) begin
                full_hi <= 1'b0;
                full_lo <= 1'b0;
            end else if (rsel) begin
                hold_hi <= corr;
                full_hi <= 1'b1;
            end else begin
                hold_lo <= corr;
                full_lo <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/pgc_step_sched.sv
module pgc_step_sched #(
    parameter int CNT_W     = 22,
    parameter int FRAC      = 10,
    parameter int MU_COARSE = 10,
    parameter int MU_FINE   = 12,
    parameter int SH_W      = $clog2(MU_FINE - FRAC + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic [CNT_W-1:0] limit,
    output logic             fine,
    output logic [SH_W-1:0]  shamt
);
    localparam logic [SH_W-1:0] SH_COARSE = SH_W'(MU_COARSE - FRAC);
    localparam logic [SH_W-1:0] SH_FINE   = SH_W'(MU_FINE - FRAC);

    logic [CNT_W-1:0] cnt;

    // R9: saturating sample count
    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (tick && (cnt != '1)) begin
            cnt <= cnt + CNT_W'(1);
        end
    end

    always_comb begin
        fine  = (cnt >= limit);
        shamt = fine ? SH_FINE : SH_COARSE;
    end
endmodule

// File: rtl/pstage_gap_cal.sv
module pstage_gap_cal
    import pgc_pkg::*;
#(
    parameter int RAW_W     = 14,
    parameter int OUT_W     = 12,
    parameter int FRAC      = 10,
    parameter int MU_COARSE = 10,
    parameter int MU_FINE   = 12,
    parameter int CNT_W     = 22
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            in_valid,
    input  logic                            dec_lo,
    input  logic                            dec_hi,
    input  logic                            near_lo,
    input  logic                            near_hi,
    input  logic                            rsel,
    input  logic signed [RAW_W-1:0]         raw_word,
    input  logic [CNT_W-1:0]                phase_limit,
    output logic                            out_valid,
    output logic signed [OUT_W-1:0]         corr_word,
    output logic signed [RAW_W+FRAC+1:0]    gap_coef,
    output logic                            fine_step
);
    localparam int BETA_W = RAW_W + FRAC + 2;
    localparam int CORR_W = BETA_W + 1 - FRAC;
    localparam int EST_W  = CORR_W + 1;
    localparam int SH_W   = $clog2(MU_FINE - FRAC + 1);
    localparam int NCH    = 2;

    stage_bits_t              bits;
    ref_e                     ref_code;
    logic [NCH-1:0]           ch_en;
    logic [NCH-1:0]           ch_fire;
    logic signed [EST_W-1:0]  ch_est [NCH];
    logic signed [CORR_W-1:0] corr_full;
    logic signed [OUT_W-1:0]  corr_out;
    logic [SH_W-1:0]          shamt;
    logic signed [EST_W-1:0]  est_pick;
    logic signed [BETA_W-1:0] delta;
    logic signed [BETA_W-1:0] beta_q;
    logic signed [OUT_W-1:0]  corr_q;
    logic                     valid_q;

    assign bits = '{dec_lo: dec_lo, dec_hi: dec_hi, near_lo: near_lo,
                    near_hi: near_hi, rsel: rsel};

    pgc_ref_sel u_ref (
        .in_valid (in_valid),
        .bits     (bits),
        .ref_code (ref_code),
        .ch_en    (ch_en)
    );

    pgc_corrector #(
        .RAW_W  (RAW_W),
        .OUT_W  (OUT_W),
        .FRAC   (FRAC),
        .BETA_W (BETA_W),
        .CORR_W (CORR_W)
    ) u_corr (
        .raw       (raw_word),
        .beta      (beta_q),
        .ref_code  (ref_code),
        .corr_full (corr_full),
        .corr_out  (corr_out)
    );

    // R10: one independent estimator per threshold
    for (genvar g = 0; g < NCH; g++) begin : g_chan
        pgc_est_chan #(
            .CORR_W (CORR_W),
            .EST_W  (EST_W)
        ) u_chan (
            .clk  (clk),
            .rst  (rst),
            .en   (ch_en[g]),
            .rsel (rsel),
            .corr (corr_full),
            .fire (ch_fire[g]),
            .est  (ch_est[g])
        );
    end

    pgc_step_sched #(
        .CNT_W     (CNT_W),
        .FRAC      (FRAC),
        .MU_COARSE (MU_COARSE),
        .MU_FINE   (MU_FINE),
        .SH_W      (SH_W)
    ) u_sched (
        .clk   (clk),
        .rst   (rst),
        .tick  (in_valid),
        .limit (phase_limit),
        .fine  (fine_step),
        .shamt (shamt)
    );

    // R8: at most one channel fires per sample
    always_comb begin
        est_pick = '0;
        for (int k = 0; k < NCH; k++) begin
            if (ch_fire[k]) begin
                est_pick = ch_est[k];
            end
        end
        delta = BETA_W'(est_pick) >>> shamt;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            beta_q  <= '0;
            corr_q  <= '0;
            valid_q <= 1'b0;
        end else begin
            valid_q <= in_valid;
            if (in_valid) begin
                corr_q <= corr_out;
            end
            if (|ch_fire) begin
                beta_q <= beta_q + delta;
            end
        end
    end

    assign out_valid = valid_q;
    assign corr_word = corr_q;
    assign gap_coef  = beta_q;
endmodule

// File: rtl/pstage_gap_cal_chk.sv
module pstage_gap_cal_chk #(
    parameter int RAW_W  = 14,
    parameter int OUT_W  = 12,
    parameter int BETA_W = 26,
    parameter int CNT_W  = 22
) (
    input logic                     clk,
    input logic                     rst,
    input logic                     in_valid,
    input logic                     near_lo,
    input logic                     near_hi,
    input logic signed [RAW_W-1:0]  raw_word,
    input logic [CNT_W-1:0]         phase_limit,
    input logic                     out_valid,
    input logic signed [OUT_W-1:0]  corr_word,
    input logic signed [BETA_W-1:0] gap_coef,
    input logic                     fine_step
);
    localparam int DROP = RAW_W - OUT_W;

    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid); // R5

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!out_valid && $stable(gap_coef))); // R6

    AST_UNMARKED_HOLD: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !near_lo && !near_hi) |=> $stable(gap_coef)); // R6

    AST_BOTH_MARKS_HOLD: assert property (@(posedge clk) disable iff (rst)
        (in_valid && near_lo && near_hi) |=> $stable(gap_coef)); // R4

    AST_ZERO_GAP_PASS: assert property (@(posedge clk) disable iff (rst)
        (in_valid && gap_coef == '0) |=>
            (corr_word == OUT_W'($past(raw_word) >>> DROP))); // R5

    AST_FINE_STICKY: assert property (@(posedge clk) disable iff (rst)
        fine_step |=> (fine_step || (phase_limit != $past(phase_limit)))); // R9
endmodule

bind pstage_gap_cal pstage_gap_cal_chk #(
    .RAW_W  (RAW_W),
    .OUT_W  (OUT_W),
    .BETA_W (RAW_W + FRAC + 2),
    .CNT_W  (CNT_W)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .in_valid    (in_valid),
    .near_lo     (near_lo),
    .near_hi     (near_hi),
    .raw_word    (raw_word),
    .phase_limit (phase_limit),
    .out_valid   (out_valid),
    .corr_word   (corr_word),
    .gap_coef    (gap_coef),
    .fine_step   (fine_step)
);

// File: tb/pstage_gap_cal_tb_top.sv
module pstage_gap_cal_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int RAW_W = 14;
    localparam int OUT_W = 12;
    localparam int FRAC  = 10;
    localparam int CNT_W = 22;
    localparam int BW    = RAW_W + FRAC + 2;
    localparam longint LIMIT = 100;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic in_valid = 1'b0;
    logic dec_lo = 1'b0, dec_hi = 1'b0, near_lo = 1'b0, near_hi = 1'b0, rsel = 1'b0;
    logic signed [RAW_W-1:0] raw_word = '0;
    logic [CNT_W-1:0] phase_limit = CNT_W'(LIMIT);
    logic out_valid;
    logic signed [OUT_W-1:0] corr_word;
    logic signed [BW-1:0] gap_coef;
    logic fine_step;

    int checks = 0;
    int fails = 0;

    // reference model state
    longint mbeta;
    longint mcnt;
    longint h_hi [2];
    longint h_lo [2];
    bit     f_hi [2];
    bit     f_lo [2];

    always #(CLK_PERIOD / 2) clk = ~clk;

    pstage_gap_cal #(
        .RAW_W (RAW_W), .OUT_W (OUT_W), .FRAC (FRAC),
        .MU_COARSE (10), .MU_FINE (12), .CNT_W (CNT_W)
    ) dut_i (
        .clk (clk), .rst (rst), .in_valid (in_valid),
        .dec_lo (dec_lo), .dec_hi (dec_hi), .near_lo (near_lo), .near_hi (near_hi),
        .rsel (rsel), .raw_word (raw_word), .phase_limit (phase_limit),
        .out_valid (out_valid), .corr_word (corr_word), .gap_coef (gap_coef),
        .fine_step (fine_step)
    );

    task automatic chk(string tag, longint act, longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic model_clear();
        mbeta = 0;
        mcnt  = 0;
        for (int k = 0; k < 2; k++) begin
            h_hi[k] = 0; h_lo[k] = 0; f_hi[k] = 0; f_lo[k] = 0;
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        in_valid = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        chk("R1 out_valid", longint'(out_valid), 0);
        chk("R1 corr_word", longint'(corr_word), 0);
        chk("R1 gap_coef", longint'(gap_coef), 0);
        chk("R1 fine_step", longint'(fine_step), 0);
        @(negedge clk);
        rst = 1'b0;
        model_clear();
    endtask

    task automatic send(bit d1, bit d2, bit f1, bit f2, bit r, longint raw);
        longint s, prod, corr, o, est;
        bit lo, hi, clamped, upd, fine_now;
        int ch;
        @(negedge clk);
        in_valid = 1'b1;
        dec_lo = d1; dec_hi = d2; near_lo = f1; near_hi = f2; rsel = r;
        raw_word = RAW_W'(raw);
        lo = f1 && !f2;
        hi = f2 && !f1;
        if (lo)      s = r ? 0 : -1;
        else if (hi) s = r ? 1 : 0;
        else         s = longint'(d1) + longint'(d2) - 1;
        prod = (s * mbeta + 512) >>> 10;
        corr = raw - prod;
        o = corr >>> 2;
        clamped = 0;
        if (o > 2047)  begin o = 2047;  clamped = 1; end
        if (o < -2048) begin o = -2048; clamped = 1; end
        fine_now = (mcnt >= LIMIT);
        ch = lo ? 0 : (hi ? 1 : -1);
        upd = 0;
        est = 0;
        if (ch >= 0) begin
            if (r) begin
                if (f_lo[ch]) begin est = corr - h_lo[ch]; upd = 1; end
                else begin h_hi[ch] = corr; f_hi[ch] = 1; end
            end else begin
                if (f_hi[ch]) begin est = h_hi[ch] - corr; upd = 1; end
                else begin h_lo[ch] = corr; f_lo[ch] = 1; end
            end
            if (upd) begin
                mbeta = mbeta + (est >>> (fine_now ? 2 : 0));
                f_hi[ch] = 0;
                f_lo[ch] = 0;
            end
        end
        mcnt++;
        @(posedge clk);
        #1;
        chk("R5 out_valid", longint'(out_valid), 1);
        if (clamped)           chk("R11 corr_word", longint'(corr_word), o);
        else if (f1 && f2)     chk("R4 corr_word", longint'(corr_word), o);
        else if (lo || hi)     chk("R3 corr_word", longint'(corr_word), o);
        else                   chk("R2 corr_word", longint'(corr_word), o);
        if (upd)               chk("R8 gap_coef", longint'(gap_coef), mbeta);
        else if (f1 && f2)     chk("R4 gap_coef", longint'(gap_coef), mbeta);
        else if (lo || hi)     chk("R7 gap_coef", longint'(gap_coef), mbeta);
        else                   chk("R6 gap_coef", longint'(gap_coef), mbeta);
        chk("R9 fine_step", longint'(fine_step), longint'(mcnt >= LIMIT));
    endtask

    task automatic idle();
        @(negedge clk);
        in_valid = 1'b0;
        raw_word = RAW_W'(1234);
        near_hi = 1'b1;
        rsel = 1'b1;
        @(posedge clk);
        #1;
        chk("R6 idle out_valid", longint'(out_valid), 0);
        chk("R6 idle gap_coef", longint'(gap_coef), mbeta);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        longint raws [7];
        raws[0] = 8191; raws[1] = -8192; raws[2] = 37; raws[3] = -1500;
        raws[4] = 4000; raws[5] = 0;     raws[6] = -6001;
        do_reset();

        // sweep every control combination across raw values; crosses LIMIT
        for (int ri = 0; ri < 6; ri++) begin
            for (int code = 0; code < 32; code++) begin
                send(code[4], code[3], code[2], code[1], code[0],
                     raws[(code * 5 + ri) % 7]);
            end
        end
        idle();
        idle();

        // directed: overwrite of a filled slot, cross-channel isolation
        do_reset();
        send(0, 0, 1, 0, 1, 400);
        send(0, 0, 1, 0, 1, 800);
        send(1, 0, 1, 0, 0, 100);
        chk("R7 overwrite pair", longint'(gap_coef), 700);
        send(1, 1, 0, 1, 1, 50);
        send(0, 0, 1, 0, 0, 0);
        chk("R10 cross pair", longint'(gap_coef), 700);
        send(0, 0, 1, 1, 1, 20);
        chk("R4 both marks", longint'(gap_coef), 700);
        send(1, 1, 0, 1, 0, -300);
        idle();

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule